// File: doc/BRIEF.md
# Eight-Region Memory Protection Unit

The unit checks every memory access against eight software-programmed address windows. An access arrives as an address, a privilege flag and an access kind: data read, data write or instruction fetch. In the same cycle the unit answers whether the access is permitted. It also returns three attributes: data-cacheable, write-buffered and code-cacheable. The lookup is purely combinational. Each window has its own base/size comparator, and the highest-numbered matching window wins.

Software configures the unit through a single-cycle register-write port. The port reaches the eight window registers, two packed permission words (data and code), three one-bit-per-window attribute masks and a control word. The control word enables the protection checks, the data-side attributes and the code-side attributes. A write changes the lookup result from the cycle after the one in which it is presented.

Top module: `mpu_top`

## Requirements
- R1: After reset all window registers, permission words, masks and the control word read as zero. The unit is therefore off: kinds 0 to 2 are allowed and all three attributes are 0.
- R2: With control bit 0 clear, kinds 0 (read), 1 (write) and 2 (fetch) are allowed at any address and privilege. In this state data-cacheable and write-buffered both equal control bit 2, and code-cacheable equals control bit 12.
- R3: A window register uses bit 0 as enable, bits 5:1 as an exponent N giving a size of 2<<N bytes, and bits 31:12 as the 4 KB page base. An address hits when (addr[31:12] - base) modulo 2^20 is below the size in pages. Any size under 4 KB counts as one page.
- R4: When several enabled windows hit, only the highest-numbered one supplies permissions and attributes.
- R5: Data permission codes, where privileged means acc_priv=1: code 1 gives privileged read/write; code 2 gives privileged read/write plus user read; code 3 gives read/write in both modes; code 5 gives privileged read only; code 6 gives read only in both modes. Codes 0, 4, 7 and 8 to 15 grant nothing.
- R6: Code permission codes: codes 1 and 5 allow fetch for privileged accesses only. Codes 2, 3 and 6 allow fetch in both modes. Every other code forbids fetch.
- R7: With the unit on, an address that hits no enabled window is denied for every kind and gets no attributes.
- R8: With the unit on, data-cacheable is set when control bit 2 is set and the winning window's data-cacheable mask bit is set. Write-buffered additionally needs the window's write-buffer mask bit. Code-cacheable is set when control bit 12 is set and the window's code-cacheable mask bit is set. The attributes do not depend on the access kind.
- R9: Register select codes: 0 to 7 select window n, 8 the data permission word, 9 the code permission word, 10 the data-cacheable mask, 11 the code-cacheable mask, 12 the write-buffer mask and 13 the control word. Writes to codes 14 and 15 change nothing. A write takes effect on the lookup from the next cycle on.
- R10: Access kind 3 is reserved and is never allowed.
- R11: Window n takes its permission codes from bits 4n+3:4n of each permission word and its attribute bits from bit n of each mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 4 | Register select (see R9) |
| cfg_wdata | input | 32 | Register write data |
| acc_addr | input | 32 | Access byte address |
| acc_priv | input | 1 | 1 = privileged access, 0 = user access |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 reserved |
| acc_ok | output | 1 | Access permitted |
| attr_dcache | output | 1 | Data-cacheable attribute |
| attr_wbuf | output | 1 | Write-buffered attribute |
| attr_icache | output | 1 | Code-cacheable attribute |

## Verification
A register write and a lookup can occur in the same cycle. The bench presents a write strobe together with an access, for example switching the unit off while a user read is pending. It then checks that the answer in that cycle still reflects the old configuration and that the new answer appears only after the clock edge. A second overlap is window priority: one address hits two or three enabled windows at once. The tables are chosen so that the lower window would give a different answer from the higher one, and the bench expects the higher one.

// File: rtl/mpu_pkg.sv
package mpu_pkg;

    localparam int N_REGION   = 8;
    localparam int ADDR_W     = 32;
    localparam int PAGE_SHIFT = 12;
    localparam int PAGE_W     = ADDR_W - PAGE_SHIFT;
    localparam int SEL_W      = 4;
    localparam int CODE_W     = 4;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic [PAGE_W-1:0] base;
        logic [4:0]        exp;
        logic              en;
    } region_t;

    typedef struct packed {
        logic ok;
        logic dcache;
        logic wbuf;
        logic icache;
    } verdict_t;

    function automatic logic data_read_ok(input logic [CODE_W-1:0] c, input logic priv);
        case (c)
            4'd1, 4'd5:       data_read_ok = priv;
            4'd2, 4'd3, 4'd6: data_read_ok = 1'b1;
            default:          data_read_ok = 1'b0;
        endcase
    endfunction

    function automatic logic data_write_ok(input logic [CODE_W-1:0] c, input logic priv);
        case (c)
            4'd1, 4'd2: data_write_ok = priv;
            4'd3:       data_write_ok = 1'b1;
            default:    data_write_ok = 1'b0;
        endcase
    endfunction

    function automatic logic fetch_ok(input logic [CODE_W-1:0] c, input logic priv);
        case (c)
            4'd1, 4'd5:       fetch_ok = priv;
            4'd2, 4'd3, 4'd6: fetch_ok = 1'b1;
            default:          fetch_ok = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/mpu_cfg_regs.sv
module mpu_cfg_regs
    import mpu_pkg::*;
#(
    parameter int NREG = N_REGION,
    parameter int DW   = ADDR_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [SEL_W-1:0]         sel,
    input  logic [DW-1:0]            wdata,
    output region_t [NREG-1:0]       regions,
    output logic [CODE_W*NREG-1:0]   dperm,
    output logic [CODE_W*NREG-1:0]   cperm,
    output logic [NREG-1:0]          dc_mask,
    output logic [NREG-1:0]          ic_mask,
    output logic [NREG-1:0]          wb_mask,
    output logic                     ctl_en,
    output logic                     ctl_dc,
    output logic                     ctl_ic
);
    localparam int PW = CODE_W * NREG;
    localparam logic [SEL_W-1:0] SEL_DPERM = SEL_W'(NREG);
    localparam logic [SEL_W-1:0] SEL_CPERM = SEL_W'(NREG + 1);
    localparam logic [SEL_W-1:0] SEL_DCM   = SEL_W'(NREG + 2);
    localparam logic [SEL_W-1:0] SEL_ICM   = SEL_W'(NREG + 3);
    localparam logic [SEL_W-1:0] SEL_WBM   = SEL_W'(NREG + 4);
    localparam logic [SEL_W-1:0] SEL_CTL   = SEL_W'(NREG + 5);

    for (genvar g = 0; g < NREG; g++) begin : g_rgn
        always_ff @(posedge clk) begin
            if (rst) begin
                regions[g] <= '0;
            end else if (we && sel == SEL_W'(g)) begin
                regions[g].base <= wdata[DW-1:PAGE_SHIFT];
                regions[g].exp  <= wdata[5:1];
                regions[g].en   <= wdata[0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dperm   <= '0;
            cperm   <= '0;
            dc_mask <= '0;
            ic_mask <= '0;
            wb_mask <= '0;
            ctl_en  <= 1'b0;
            ctl_dc  <= 1'b0;
            ctl_ic  <= 1'b0;
        end else if (we) begin
            case (sel)
                SEL_DPERM: dperm   <= wdata[PW-1:0];
                SEL_CPERM: cperm   <= wdata[PW-1:0];
                SEL_DCM:   dc_mask <= wdata[NREG-1:0];
                SEL_ICM:   ic_mask <= wdata[NREG-1:0];
                SEL_WBM:   wb_mask <= wdata[NREG-1:0];
                SEL_CTL: begin
                    ctl_en <= wdata[0];
                    ctl_dc <= wdata[2];
                    ctl_ic <= wdata[12];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/mpu_region_match.sv
module mpu_region_match
    import mpu_pkg::*;
(
    input  region_t           rgn,
    input  logic [PAGE_W-1:0] page,
    output logic              hit
);
    localparam logic [4:0]      EXP_MIN = 5'(PAGE_SHIFT - 1);
    localparam logic [4:0]      SH_MAX  = 5'(PAGE_W);
    localparam logic [PAGE_W:0] ONE     = (PAGE_W + 1)'(1);

    logic [4:0]        sh;
    logic [PAGE_W:0]   pages;
    logic [PAGE_W-1:0] off;

    always_comb begin
        sh = (rgn.exp >= EXP_MIN) ? (rgn.exp - EXP_MIN) : 5'd0;
        if (sh > SH_MAX) sh = SH_MAX;
        pages = ONE << sh;
        off   = page - rgn.base;
        hit   = rgn.en && ({1'b0, off} < pages);
    end

endmodule

// File: rtl/mpu_resolve.sv
module mpu_resolve
    import mpu_pkg::*;
#(
    parameter int NREG = N_REGION
) (
    input  logic [NREG-1:0]        hits,
    input  logic [CODE_W*NREG-1:0] dperm,
    input  logic [CODE_W*NREG-1:0] cperm,
    input  logic [NREG-1:0]        dc_mask,
    input  logic [NREG-1:0]        ic_mask,
    input  logic [NREG-1:0]        wb_mask,
    input  logic                   ctl_en,
    input  logic                   ctl_dc,
    input  logic                   ctl_ic,
    input  logic                   priv,
    input  acc_kind_e              kind,
    output verdict_t               verdict
);
    localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

    logic              any_hit;
    logic [IW-1:0]     win;
    logic [CODE_W-1:0] dcode;
    logic [CODE_W-1:0] ccode;
    logic              perm_ok;

    always_comb begin
        any_hit = 1'b0;
        win     = '0;
        for (int i = 0; i < NREG; i++) begin
            if (hits[i]) begin
                any_hit = 1'b1;
                win     = IW'(i);
            end
        end
        dcode = dperm[win*CODE_W +: CODE_W];
        ccode = cperm[win*CODE_W +: CODE_W];
        case (kind)
            ACC_READ:  perm_ok = data_read_ok(dcode, priv);
            ACC_WRITE: perm_ok = data_write_ok(dcode, priv);
            ACC_FETCH: perm_ok = fetch_ok(ccode, priv);
            default:   perm_ok = 1'b0;
        endcase

        if (!ctl_en) begin
            verdict.ok     = (kind != ACC_RSVD);
            verdict.dcache = ctl_dc;
            verdict.wbuf   = ctl_dc;
            verdict.icache = ctl_ic;
        end else if (any_hit) begin
            verdict.ok     = perm_ok;
            verdict.dcache = ctl_dc & dc_mask[win];
            verdict.wbuf   = ctl_dc & dc_mask[win] & wb_mask[win];
            verdict.icache = ctl_ic & ic_mask[win];
        end else begin
            verdict = '0;
        end
    end

endmodule

// File: rtl/mpu_top.sv
module mpu_top
    import mpu_pkg::*;
#(
    parameter int NREG = N_REGION,
    parameter int AW   = ADDR_W,
    parameter int SW   = SEL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [SW-1:0] cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic [AW-1:0] acc_addr,
    input  logic          acc_priv,
    input  logic [1:0]    acc_kind,
    output logic          acc_ok,
    output logic          attr_dcache,
    output logic          attr_wbuf,
    output logic          attr_icache
);
    region_t [NREG-1:0]       regions;
    logic [CODE_W*NREG-1:0]   dperm;
    logic [CODE_W*NREG-1:0]   cperm;
    logic [NREG-1:0]          dc_mask;
    logic [NREG-1:0]          ic_mask;
    logic [NREG-1:0]          wb_mask;
    logic                     ctl_en;
    logic                     ctl_dc;
    logic                     ctl_ic;
    logic [NREG-1:0]          hits;
    verdict_t                 verdict;
    logic                     unused_offset;

    assign unused_offset = ^acc_addr[PAGE_SHIFT-1:0];

    mpu_cfg_regs #(.NREG(NREG), .DW(AW)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .sel     (cfg_sel),
        .wdata   (cfg_wdata),
        .regions (regions),
        .dperm   (dperm),
        .cperm   (cperm),
        .dc_mask (dc_mask),
        .ic_mask (ic_mask),
        .wb_mask (wb_mask),
        .ctl_en  (ctl_en),
        .ctl_dc  (ctl_dc),
        .ctl_ic  (ctl_ic)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_match
        mpu_region_match u_match (
            .rgn  (regions[g]),
            .page (acc_addr[AW-1:PAGE_SHIFT]),
            .hit  (hits[g])
        );
    end

    mpu_resolve #(.NREG(NREG)) u_resolve (
        .hits    (hits),
        .dperm   (dperm),
        .cperm   (cperm),
        .dc_mask (dc_mask),
        .ic_mask (ic_mask),
        .wb_mask (wb_mask),
        .ctl_en  (ctl_en),
        .ctl_dc  (ctl_dc),
        .ctl_ic  (ctl_ic),
        .priv    (acc_priv),
        .kind    (acc_kind_e'(acc_kind)),
        .verdict (verdict)
    );

    assign acc_ok      = verdict.ok;
    assign attr_dcache = verdict.dcache;
    assign attr_wbuf   = verdict.wbuf;
    assign attr_icache = verdict.icache;

endmodule

// File: rtl/mpu_checker.sv
module mpu_checker (
    input logic        clk,
    input logic        rst,
    input logic        cfg_we,
    input logic [31:0] acc_addr,
    input logic        acc_priv,
    input logic [1:0]  acc_kind,
    input logic        acc_ok,
    input logic        attr_dcache,
    input logic        attr_wbuf,
    input logic        attr_icache,
    input logic        ctl_en,
    input logic        ctl_dc,
    input logic        ctl_ic
);
    // R10: reserved kind is never granted
    a_r10_rsvd_denied: assert property (@(posedge clk) disable iff (rst)
        acc_kind == 2'd3 |-> !acc_ok);

    // R8: write-buffered only together with data-cacheable
    a_r8_wbuf_needs_dc: assert property (@(posedge clk) disable iff (rst)
        attr_wbuf |-> attr_dcache);

    // R8: control gates the data-side attributes
    a_r8_dc_gated: assert property (@(posedge clk) disable iff (rst)
        (ctl_en && !ctl_dc) |-> (!attr_dcache && !attr_wbuf));

    // R8: control gates the code-side attribute
    a_r8_ic_gated: assert property (@(posedge clk) disable iff (rst)
        (ctl_en && !ctl_ic) |-> !attr_icache);

    // R2: unit off grants every defined kind
    a_r2_off_grants: assert property (@(posedge clk) disable iff (rst)
        (!ctl_en && acc_kind != 2'd3) |-> acc_ok);

    // R2: unit off attributes follow the control bits
    a_r2_off_attrs: assert property (@(posedge clk) disable iff (rst)
        !ctl_en |-> (attr_dcache == ctl_dc && attr_wbuf == ctl_dc && attr_icache == ctl_ic));

    // R1: first cycle after reset behaves as an idle, disabled unit
    a_r1_after_reset: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && acc_kind != 2'd3) |-> (acc_ok && !attr_dcache && !attr_wbuf && !attr_icache));

    // R9: without a write the answer for an unchanged access does not move
    a_r9_no_write_stable: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(cfg_we) && $stable(acc_addr) && $stable(acc_priv) && $stable(acc_kind))
        |-> ($stable(acc_ok) && $stable(attr_dcache) && $stable(attr_wbuf) && $stable(attr_icache)));

endmodule

bind mpu_top mpu_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_we      (cfg_we),
    .acc_addr    (acc_addr),
    .acc_priv    (acc_priv),
    .acc_kind    (acc_kind),
    .acc_ok      (acc_ok),
    .attr_dcache (attr_dcache),
    .attr_wbuf   (attr_wbuf),
    .attr_icache (attr_icache),
    .ctl_en      (ctl_en),
    .ctl_dc      (ctl_dc),
    .ctl_ic      (ctl_ic)
);

// File: tb/mpu_top_tb.sv
`timescale 1ns/100ps
module mpu_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] acc_addr = '0;
    logic        acc_priv = 1'b0;
    logic [1:0]  acc_kind = '0;
    logic        acc_ok, attr_dcache, attr_wbuf, attr_icache;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    mpu_top dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .acc_addr(acc_addr), .acc_priv(acc_priv), .acc_kind(acc_kind),
        .acc_ok(acc_ok), .attr_dcache(attr_dcache), .attr_wbuf(attr_wbuf), .attr_icache(attr_icache)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic        priv;
        logic [1:0]  kind;
        logic [3:0]  exp;   // {ok, dcache, wbuf, icache}
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VEC [NV] = '{
        '{32'h0000_1000, 1'b1, 2'd0, 4'b1000, 4'd5},   // R5 code 1 priv read
        '{32'h0000_1000, 1'b0, 2'd0, 4'b0000, 4'd5},   // R5 code 1 user read denied
        '{32'h0000_1000, 1'b1, 2'd2, 4'b0000, 4'd6},   // R6 code 0 no fetch
        '{32'h0200_0010, 1'b0, 2'd1, 4'b1101, 4'd8},   // R8 code 3 user write, dc+ic
        '{32'h0200_0010, 1'b0, 2'd2, 4'b1101, 4'd6},   // R6 code 2 user fetch
        '{32'h023F_FFFC, 1'b1, 2'd1, 4'b1101, 4'd3},   // R3 last page of 4 MB window
        '{32'h0240_0000, 1'b1, 2'd1, 4'b1000, 4'd3},   // R3 one past the end
        '{32'h0210_0000, 1'b0, 2'd0, 4'b1110, 4'd4},   // R4 window 2 beats window 1
        '{32'h0210_0000, 1'b0, 2'd1, 4'b0110, 4'd4},   // R4 code 6 forbids write
        '{32'h0210_FFFF, 1'b1, 2'd2, 4'b1110, 4'd6},   // R6 code 6 fetch
        '{32'h0211_0000, 1'b0, 2'd1, 4'b1101, 4'd3},   // R3 above 64 KB window
        '{32'h0400_0FFF, 1'b0, 2'd0, 4'b1001, 4'd3},   // R3 tiny size is one page
        '{32'h0400_0FFF, 1'b0, 2'd1, 4'b0001, 4'd5},   // R5 code 2 user write denied
        '{32'h0400_1000, 1'b0, 2'd0, 4'b0000, 4'd3},   // R3 second page misses
        '{32'h0400_0000, 1'b0, 2'd2, 4'b0001, 4'd6},   // R6 code 5 user fetch denied
        '{32'h0400_0000, 1'b1, 2'd2, 4'b1001, 4'd6},   // R6 code 5 priv fetch
        '{32'h0500_0000, 1'b1, 2'd1, 4'b0000, 4'd8},   // R8 wbuf bit alone gives nothing
        '{32'h0500_0000, 1'b1, 2'd0, 4'b1000, 4'd5},   // R5 code 5 priv read
        '{32'h0500_0000, 1'b0, 2'd2, 4'b0000, 4'd6},   // R6 code 1 user fetch denied
        '{32'h0600_1FFC, 1'b1, 2'd0, 4'b0000, 4'd5},   // R5 code 7 grants nothing
        '{32'h0600_1FFC, 1'b1, 2'd2, 4'b0000, 4'd6},   // R6 code 4 grants nothing
        '{32'h0600_2000, 1'b1, 2'd0, 4'b1000, 4'd3},   // R3 8 KB window end
        '{32'h0800_0000, 1'b0, 2'd0, 4'b0000, 4'd3},   // R3 disabled window 6 ignored
        '{32'h0200_0000, 1'b1, 2'd3, 4'b0101, 4'd10},  // R10 reserved kind
        '{32'h0200_0000, 1'b1, 2'd0, 4'b1101, 4'd11}   // R11 window 1 field
    };

    task automatic wr(input logic [3:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic judge(input string tag, input logic [3:0] exp);
        logic [3:0] act;
        act = {acc_ok, attr_dcache, attr_wbuf, attr_icache};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%h priv=%0d kind=%0d actual=%b expected=%b",
                     tag, acc_addr, acc_priv, acc_kind, act, exp);
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] a, input logic p,
                       input logic [1:0] k, input logic [3:0] exp);
        @(negedge clk);
        acc_addr = a; acc_priv = p; acc_kind = k;
        #1;
        judge(tag, exp);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        chk("R1 read",  32'h0200_0000, 1'b0, 2'd0, 4'b1000);
        chk("R1 write", 32'h0200_0000, 1'b0, 2'd1, 4'b1000);
        chk("R1 fetch", 32'h0200_0000, 1'b0, 2'd2, 4'b1000);

        // configuration
        wr(4'd0, 32'h0000_003F);
        wr(4'd1, 32'h0200_002B);
        wr(4'd2, 32'h0210_001F);
        wr(4'd3, 32'h0400_000B);
        wr(4'd4, 32'h0500_0017);
        wr(4'd5, 32'h0600_0019);
        wr(4'd6, 32'h0800_0028);
        wr(4'd7, 32'h0000_0000);
        wr(4'd8, 32'h0375_2631);
        wr(4'd9, 32'h0341_5620);
        wr(4'd10, 32'h0000_0006);
        wr(4'd11, 32'h0000_000A);
        wr(4'd12, 32'h0000_0014);
        wr(4'd13, 32'h0000_1005);

        for (int i = 0; i < NV; i++) begin
            chk($sformatf("R%0d table row %0d", VEC[i].req, i), VEC[i].addr, VEC[i].priv,
                VEC[i].kind, VEC[i].exp);
        end

        // R8 cache gating by control bits
        wr(4'd13, 32'h0000_0001);
        chk("R8 dc off", 32'h0210_0000, 1'b0, 2'd0, 4'b1000);
        wr(4'd13, 32'h0000_1001);
        chk("R8 ic only", 32'h0200_0000, 1'b1, 2'd0, 4'b1001);

        // R9 write and lookup in the same cycle
        @(negedge clk);
        acc_addr = 32'h0000_1000; acc_priv = 1'b0; acc_kind = 2'd0;
        cfg_we = 1'b1; cfg_sel = 4'd13; cfg_wdata = 32'h0;
        #1 judge("R9 old config in write cycle", 4'b0000);
        @(posedge clk); #1;
        judge("R9 new config after edge", 4'b1000);
        @(negedge clk); cfg_we = 1'b0;

        // R9 unused selects change nothing
        wr(4'd14, 32'hFFFF_FFFF);
        wr(4'd15, 32'hFFFF_FFFF);
        chk("R9 sel 14/15 ignored", 32'h0000_1000, 1'b0, 2'd0, 4'b1000);

        // R2 unit off with attributes on
        wr(4'd13, 32'h0000_1004);
        chk("R2 off write",  32'h0200_0000, 1'b0, 2'd1, 4'b1111);
        chk("R2 off fetch",  32'h0900_0000, 1'b0, 2'd2, 4'b1111);
        chk("R10 off rsvd",  32'h0200_0000, 1'b1, 2'd3, 4'b0111);

        // R7 no matching window
        wr(4'd13, 32'h0000_1005);
        wr(4'd0, 32'h0000_0000);
        chk("R7 miss read",  32'h0800_0000, 1'b1, 2'd0, 4'b0000);
        chk("R7 miss fetch", 32'h0000_1000, 1'b1, 2'd2, 4'b0000);

        // R11 field position: clear only window 1's data code
        wr(4'd8, 32'h0375_2601);
        chk("R11 window 1 cleared", 32'h0200_0000, 1'b0, 2'd0, 4'b0101);
        chk("R11 window 2 kept",    32'h0210_0000, 1'b0, 2'd0, 4'b1110);

        // R1 reset after configuration
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1 re-reset", 32'h0210_0000, 1'b0, 2'd1, 4'b1000);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule